// File: doc/BRIEF.md
# Dual-Port Mailbox with Interrupts

This block is a pair of 32-bit mailboxes placed between two bus masters: a host side and an add-on side. Each side writes an outbox and reads an inbox. The host outbox is the add-on inbox, and the add-on outbox is the host inbox. Both sides reach four registers through a simple register port. The port has an address, one-cycle write and read strobes and four byte enables. An 8-bit access uses one byte enable, a 16-bit access uses the lower or upper pair, and a 32-bit access uses all four.

Every mailbox byte has a full flag. Writing the byte sets its flag. The peer reading that byte clears it. Both sides read the full flags in one shared status register. Each side also has its own interrupt control register. It holds an enable and a 2-bit byte-lane select for an inbound event and for an outbound event.

An inbound event is the peer writing the selected byte into this side's inbox. An outbound event is the peer reading the selected byte out of this side's outbox, which means the mailbox was drained. An enabled event sets a sticky flag. Only writing 1 to that flag clears it. The side's interrupt line is the OR of its two flags.

Register map, the same on both sides (2-bit address): 0 = inbox (read; a read with byte enables consumes those bytes), 1 = outbox (write; reads return the last value written), 2 = interrupt control, 3 = status and flush.

Top module: `mbox_bridge`

## Requirements
- R1: A write to register 1 updates only the outbox bytes whose byte enable is set. A read of register 1 returns the outbox contents and has no side effect.
- R2: Writing byte k of an outbox sets that byte's full flag, and the peer sees the data at its register 0. A peer read of register 0 with byte enable k clears flag k only. If a write and a peer read hit the same byte in one cycle, the flag ends set.
- R3: Register 3 reads the same on both sides. Bits 15:12 are the host-to-add-on full flags (bit 12 is byte 0). Bits 31:28 are the add-on-to-host full flags (bit 28 is byte 0). All other bits read 0.
- R4: A write to register 3 from either side with byte enable 3 set and data bit 27 set clears every full flag at the next edge, and this overrides a full-flag set in the same cycle. Mailbox data is kept.
- R5: Register 2 has this layout. Bit 0 is the inbound enable and bit 1 the outbound enable. Bits 3:2 are the inbound lane and bits 5:4 the outbound lane. Bit 8 is the inbound flag and bit 9 the outbound flag. All other bits read 0. Bits 5:0 are written only when byte enable 0 is set.
- R6: While the inbound enable is 1, a peer write to the peer's register 1 that includes the selected inbound lane sets the inbound flag at that edge. While the outbound enable is 1, a peer read of the peer's register 0 that includes the selected outbound lane sets the outbound flag. Accesses to other lanes do not set the flags.
- R7: Flags clear only when a write to register 2 has byte enable 1 set and carries 1 in the flag's bit. Writing 0 there, or clearing an enable, leaves a set flag unchanged. A set event and a clear in the same cycle leave the flag set.
- R8: Each side's interrupt output equals the OR of its inbound and outbound flags.
- R9: After reset, every register on both sides reads 0 and both interrupt outputs are low.
- R10: Writes to register 0 are ignored. The inbox contents and the full flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 2 | Host register select |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (side effects only) |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr, combinational |
| h_irq | output | 1 | Host interrupt level |
| a_addr | input | 2 | Add-on register select |
| a_wr | input | 1 | Add-on write strobe |
| a_rd | input | 1 | Add-on read strobe (side effects only) |
| a_be | input | 4 | Add-on byte enables |
| a_wdata | input | 32 | Add-on write data |
| a_rdata | output | 32 | Add-on read data for a_addr, combinational |
| a_irq | output | 1 | Add-on interrupt level |

## Verification
The bench targets these corner cases:
- **Disable after set:** the bench disables an interrupt after its flag is set and then writes 0 to the flag. A design that ties the flag to the enable would drop the interrupt here.
- **Set and clear together:** the bench clears a flag by writing 1 in the same cycle that its event fires. A clear-wins design would lose that event.
- **Write and read together:** the bench writes a byte while the peer reads it in the same cycle. A read-wins design would show an empty byte that actually holds fresh data.
- **Flush during a write:** the bench flushes the full flags while the other side is writing.
- **Unselected lanes:** the bench accesses lanes other than the selected one. A wrong lane decode would raise interrupts on the wrong byte.
- **Random traffic:** randomized cycles from both sides exercise all registers at once against the reference model.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int SEL_W  = $clog2(LANES);
  localparam int ADDR_W = 2;

  // status register layout: full-flag nibbles and flush control
  localparam int ST_H2A_LSB   = 12;
  localparam int ST_A2H_LSB   = 28;
  localparam int ST_FLUSH_BIT = 27;

  // interrupt control register layout
  localparam int CTL_IN_EN    = 0;
  localparam int CTL_OUT_EN   = 1;
  localparam int CTL_IN_SEL   = 2;
  localparam int CTL_OUT_SEL  = 4;
  localparam int CTL_IN_FLAG  = 8;
  localparam int CTL_OUT_FLAG = 9;

  typedef enum logic [ADDR_W-1:0] {
    REG_INBOX  = 2'd0,
    REG_OUTBOX = 2'd1,
    REG_IRQCTL = 2'd2,
    REG_STATUS = 2'd3
  } reg_e;

  function automatic logic [WORD_W-1:0] status_word(input logic [LANES-1:0] h2a,
                                                    input logic [LANES-1:0] a2h);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ST_H2A_LSB +: LANES] = h2a;
    w[ST_A2H_LSB +: LANES] = a2h;
    return w;
  endfunction

  function automatic logic flush_req(input logic wr, input logic [ADDR_W-1:0] addr,
                                     input logic [LANES-1:0] be,
                                     input logic [WORD_W-1:0] wdata);
    return wr && (addr == REG_STATUS) && be[ST_FLUSH_BIT / BYTE_W] && wdata[ST_FLUSH_BIT];
  endfunction
endpackage

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [LANES-1:0]  rd_be,
  input  logic              flush,
  output logic [WORD_W-1:0] data,
  output logic [LANES-1:0]  full,
  output logic [LANES-1:0]  wr_lanes,
  output logic [LANES-1:0]  rd_lanes
);
  logic [BYTE_W-1:0] byte_q [LANES];
  logic              full_q [LANES];

  assign wr_lanes = wr_en ? wr_be : '0;
  assign rd_lanes = rd_en ? rd_be : '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q[i] <= '0;
        full_q[i] <= 1'b0;
      end else begin
        if (wr_lanes[i]) byte_q[i] <= wr_data[i*BYTE_W +: BYTE_W];
        // flush beats a write, a write beats a peer read
        if (flush)            full_q[i] <= 1'b0;
        else if (wr_lanes[i]) full_q[i] <= 1'b1;
        else if (rd_lanes[i]) full_q[i] <= 1'b0;
      end
    end

    assign data[i*BYTE_W +: BYTE_W] = byte_q[i];
    assign full[i] = full_q[i];
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq import mbox_pkg::*; #(
  parameter int LANES  = 4,
  parameter int WORD_W = 32,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [LANES-1:0]  ctl_be,
  input  logic [WORD_W-1:0] ctl_wdata,
  input  logic [LANES-1:0]  in_lanes,
  input  logic [LANES-1:0]  out_lanes,
  output logic [WORD_W-1:0] ctl_word,
  output logic              in_set,
  output logic              out_set,
  output logic              irq
);
  logic             in_en, out_en, in_flag, out_flag;
  logic [SEL_W-1:0] in_sel, out_sel;
  logic [LANES-1:0] in_hot, out_hot;
  logic             cfg_wr, in_clr, out_clr;

  assign in_hot  = {{(LANES-1){1'b0}}, 1'b1} << in_sel;
  assign out_hot = {{(LANES-1){1'b0}}, 1'b1} << out_sel;

  // enable masks only the set path of each flag
  assign in_set  = in_en  && |(in_lanes  & in_hot);
  assign out_set = out_en && |(out_lanes & out_hot);

  assign cfg_wr  = ctl_wr && ctl_be[0];
  assign in_clr  = ctl_wr && ctl_be[CTL_IN_FLAG / 8]  && ctl_wdata[CTL_IN_FLAG];
  assign out_clr = ctl_wr && ctl_be[CTL_OUT_FLAG / 8] && ctl_wdata[CTL_OUT_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_en    <= 1'b0;
      out_en   <= 1'b0;
      in_sel   <= '0;
      out_sel  <= '0;
      in_flag  <= 1'b0;
      out_flag <= 1'b0;
    end else begin
      if (cfg_wr) begin
        in_en   <= ctl_wdata[CTL_IN_EN];
        out_en  <= ctl_wdata[CTL_OUT_EN];
        in_sel  <= ctl_wdata[CTL_IN_SEL  +: SEL_W];
        out_sel <= ctl_wdata[CTL_OUT_SEL +: SEL_W];
      end
      if (in_set)       in_flag <= 1'b1;
      else if (in_clr)  in_flag <= 1'b0;
      if (out_set)      out_flag <= 1'b1;
      else if (out_clr) out_flag <= 1'b0;
    end
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_IN_EN]               = in_en;
    ctl_word[CTL_OUT_EN]              = out_en;
    ctl_word[CTL_IN_SEL  +: SEL_W]    = in_sel;
    ctl_word[CTL_OUT_SEL +: SEL_W]    = out_sel;
    ctl_word[CTL_IN_FLAG]             = in_flag;
    ctl_word[CTL_OUT_FLAG]            = out_flag;
  end

  assign irq = in_flag | out_flag;
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge import mbox_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [LANES-1:0]  h_be,
  input  logic [WORD_W-1:0] h_wdata,
  output logic [WORD_W-1:0] h_rdata,
  output logic              h_irq,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [LANES-1:0]  a_be,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  output logic              a_irq
);
  logic              flush;
  logic [WORD_W-1:0] h2a_data, a2h_data, stat_word, h_ctl_word, a_ctl_word;
  logic [LANES-1:0]  h2a_full, a2h_full;
  logic [LANES-1:0]  h2a_wr_lanes, h2a_rd_lanes, a2h_wr_lanes, a2h_rd_lanes;
  logic              h_in_set, h_out_set, a_in_set, a_out_set;

  assign flush = flush_req(h_wr, h_addr, h_be, h_wdata) ||
                 flush_req(a_wr, a_addr, a_be, a_wdata);

  // host outbox, drained by add-on inbox reads
  mbox_store #(.LANES(LANES), .BYTE_W(BYTE_W)) u_h2a (
    .clk(clk), .rst_n(rst_n),
    .wr_en(h_wr && h_addr == REG_OUTBOX), .wr_be(h_be), .wr_data(h_wdata),
    .rd_en(a_rd && a_addr == REG_INBOX), .rd_be(a_be),
    .flush(flush), .data(h2a_data), .full(h2a_full),
    .wr_lanes(h2a_wr_lanes), .rd_lanes(h2a_rd_lanes)
  );

  // add-on outbox, drained by host inbox reads
  mbox_store #(.LANES(LANES), .BYTE_W(BYTE_W)) u_a2h (
    .clk(clk), .rst_n(rst_n),
    .wr_en(a_wr && a_addr == REG_OUTBOX), .wr_be(a_be), .wr_data(a_wdata),
    .rd_en(h_rd && h_addr == REG_INBOX), .rd_be(h_be),
    .flush(flush), .data(a2h_data), .full(a2h_full),
    .wr_lanes(a2h_wr_lanes), .rd_lanes(a2h_rd_lanes)
  );

  mbox_irq #(.LANES(LANES), .WORD_W(WORD_W)) u_h_irq (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(h_wr && h_addr == REG_IRQCTL), .ctl_be(h_be), .ctl_wdata(h_wdata),
    .in_lanes(a2h_wr_lanes), .out_lanes(h2a_rd_lanes),
    .ctl_word(h_ctl_word), .in_set(h_in_set), .out_set(h_out_set), .irq(h_irq)
  );

  mbox_irq #(.LANES(LANES), .WORD_W(WORD_W)) u_a_irq (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(a_wr && a_addr == REG_IRQCTL), .ctl_be(a_be), .ctl_wdata(a_wdata),
    .in_lanes(h2a_wr_lanes), .out_lanes(a2h_rd_lanes),
    .ctl_word(a_ctl_word), .in_set(a_in_set), .out_set(a_out_set), .irq(a_irq)
  );

  assign stat_word = status_word(h2a_full, a2h_full);

  always_comb begin
    case (h_addr)
      REG_INBOX:  h_rdata = a2h_data;
      REG_OUTBOX: h_rdata = h2a_data;
      REG_IRQCTL: h_rdata = h_ctl_word;
      default:    h_rdata = stat_word;
    endcase
  end

  always_comb begin
    case (a_addr)
      REG_INBOX:  a_rdata = h2a_data;
      REG_OUTBOX: a_rdata = a2h_data;
      REG_IRQCTL: a_rdata = a_ctl_word;
      default:    a_rdata = stat_word;
    endcase
  end
endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk import mbox_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] h_addr,
  input logic              h_wr,
  input logic [LANES-1:0]  h_be,
  input logic [WORD_W-1:0] h_wdata,
  input logic [WORD_W-1:0] h_rdata,
  input logic              h_irq,
  input logic [ADDR_W-1:0] a_addr,
  input logic [WORD_W-1:0] a_rdata,
  input logic              a_irq,
  input logic              flush,
  input logic [LANES-1:0]  h2a_wr_lanes,
  input logic [LANES-1:0]  h2a_full,
  input logic [LANES-1:0]  a2h_full,
  input logic              h_in_set,
  input logic              h_out_set,
  input logic              a_in_set,
  input logic              a_out_set,
  input logic [WORD_W-1:0] h_ctl_word,
  input logic [WORD_W-1:0] a_ctl_word
);
  // R2
  h2a_full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|h2a_wr_lanes && !flush) |=> ((h2a_full & $past(h2a_wr_lanes)) == $past(h2a_wr_lanes)));

  // R3
  status_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_addr == REG_STATUS && a_addr == REG_STATUS) |-> (h_rdata == a_rdata));

  // R4
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (h2a_full == '0 && a2h_full == '0));

  // R6
  h_in_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_in_set |=> h_ctl_word[CTL_IN_FLAG]);

  // R6
  a_out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_out_set |=> a_ctl_word[CTL_OUT_FLAG]);

  // R7
  h_in_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ctl_word[CTL_IN_FLAG] &&
     !(h_wr && h_addr == REG_IRQCTL && h_be[1] && h_wdata[CTL_IN_FLAG]))
    |=> h_ctl_word[CTL_IN_FLAG]);

  // R7
  h_in_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == REG_IRQCTL && h_be[1] && h_wdata[CTL_IN_FLAG] && !h_in_set)
    |=> !h_ctl_word[CTL_IN_FLAG]);

  // R8
  h_irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_irq) |-> $past(h_in_set || h_out_set));

  // R8
  a_irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_irq) |-> $past(a_in_set || a_out_set));
endmodule

bind mbox_bridge mbox_bridge_chk u_chk (.*);

// File: tb/sim_mbox_bridge.sv
`timescale 1ns/1ps
module sim_mbox_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  io_addr [2];
  logic        io_wr   [2];
  logic        io_rd   [2];
  logic [3:0]  io_be   [2];
  logic [31:0] io_wd   [2];
  logic [31:0] h_rdata, a_rdata;
  logic        h_irq, a_irq;

  mbox_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .h_addr(io_addr[0]), .h_wr(io_wr[0]), .h_rd(io_rd[0]), .h_be(io_be[0]),
    .h_wdata(io_wd[0]), .h_rdata(h_rdata), .h_irq(h_irq),
    .a_addr(io_addr[1]), .a_wr(io_wr[1]), .a_rd(io_rd[1]), .a_be(io_be[1]),
    .a_wdata(io_wd[1]), .a_rdata(a_rdata), .a_irq(a_irq)
  );

  // reference model: index 0 = host, 1 = add-on; m_box[s] is side s's outbox
  logic [7:0] m_box [2][4];
  bit         m_full [2][4];
  bit         m_en_in [2], m_en_out [2], m_fl_in [2], m_fl_out [2];
  int         m_sel_in [2], m_sel_out [2];

  int    total = 0, fails = 0;
  bit    done = 0;
  string req = "R9";

  function automatic logic [31:0] exp_rd(int s);
    logic [31:0] v = '0;
    int p = 1 - s;
    case (io_addr[s])
      2'd0: for (int k = 0; k < 4; k++) v[8*k +: 8] = m_box[p][k];
      2'd1: for (int k = 0; k < 4; k++) v[8*k +: 8] = m_box[s][k];
      2'd2: begin
        v[0] = m_en_in[s]; v[1] = m_en_out[s];
        v[3:2] = 2'(m_sel_in[s]); v[5:4] = 2'(m_sel_out[s]);
        v[8] = m_fl_in[s]; v[9] = m_fl_out[s];
      end
      default: for (int k = 0; k < 4; k++) begin
        v[12 + k] = m_full[0][k];
        v[28 + k] = m_full[1][k];
      end
    endcase
    return v;
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_update();
    bit fl = 0;
    bit ev_in [2], ev_out [2];
    for (int s = 0; s < 2; s++)
      if (io_wr[s] && io_addr[s] == 2'd3 && io_be[s][3] && io_wd[s][27]) fl = 1;
    for (int s = 0; s < 2; s++) begin
      int p = 1 - s;
      ev_in[s]  = m_en_in[s]  && io_wr[p] && io_addr[p] == 2'd1 && io_be[p][m_sel_in[s]];
      ev_out[s] = m_en_out[s] && io_rd[p] && io_addr[p] == 2'd0 && io_be[p][m_sel_out[s]];
    end
    for (int s = 0; s < 2; s++) begin
      int p = 1 - s;
      if (io_wr[s] && io_addr[s] == 2'd2) begin
        if (io_be[s][1]) begin
          if (io_wd[s][8]) m_fl_in[s] = 0;
          if (io_wd[s][9]) m_fl_out[s] = 0;
        end
        if (io_be[s][0]) begin
          m_en_in[s] = io_wd[s][0]; m_en_out[s] = io_wd[s][1];
          m_sel_in[s] = int'(io_wd[s][3:2]); m_sel_out[s] = int'(io_wd[s][5:4]);
        end
      end
      if (ev_in[s])  m_fl_in[s] = 1;
      if (ev_out[s]) m_fl_out[s] = 1;
      for (int k = 0; k < 4; k++) begin
        bit wrote = io_wr[s] && io_addr[s] == 2'd1 && io_be[s][k];
        bit taken = io_rd[p] && io_addr[p] == 2'd0 && io_be[p][k];
        if (wrote) m_box[s][k] = io_wd[s][8*k +: 8];
        if (fl) m_full[s][k] = 0;
        else if (wrote) m_full[s][k] = 1;
        else if (taken) m_full[s][k] = 0;
      end
    end
  endtask

  task automatic step();
    #1;
    check("host rdata", h_rdata, exp_rd(0));
    check("addon rdata", a_rdata, exp_rd(1));
    check("host irq", {31'b0, h_irq}, {31'b0, m_fl_in[0] | m_fl_out[0]});
    check("addon irq", {31'b0, a_irq}, {31'b0, m_fl_in[1] | m_fl_out[1]});
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    for (int s = 0; s < 2; s++) begin
      io_wr[s] = 0; io_rd[s] = 0; io_be[s] = 4'h0; io_wd[s] = '0;
    end
  endtask

  task automatic acc(int s, logic [1:0] adr, bit wr, bit rd, logic [3:0] be, logic [31:0] wd);
    io_addr[s] = adr; io_wr[s] = wr; io_rd[s] = rd; io_be[s] = be; io_wd[s] = wd;
  endtask

  task automatic peek(logic [1:0] ha, logic [1:0] aa);
    idle(); io_addr[0] = ha; io_addr[1] = aa; step();
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      io_addr[s] = 2'd0;
      m_en_in[s] = 0; m_en_out[s] = 0; m_fl_in[s] = 0; m_fl_out[s] = 0;
      m_sel_in[s] = 0; m_sel_out[s] = 0;
      for (int k = 0; k < 4; k++) begin m_box[s][k] = '0; m_full[s][k] = 0; end
    end
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: all registers zero after reset
    req = "R9";
    for (int r = 0; r < 4; r++) peek(2'(r), 2'(3 - r));

    // R1: partial writes and readback of the outbox
    req = "R1";
    idle(); acc(0, 2'd1, 1, 0, 4'hF, 32'hA1B2C3D4); step();
    idle(); acc(0, 2'd1, 1, 0, 4'h4, 32'h00EE0000); step();
    idle(); acc(0, 2'd1, 0, 1, 4'hF, 32'h0); step();
    peek(2'd1, 2'd0);

    // R2: peer drains halves, then a same-cycle write and read of one byte
    req = "R2";
    peek(2'd3, 2'd0);
    idle(); acc(1, 2'd0, 0, 1, 4'h3, 0); step();
    peek(2'd3, 2'd3);
    idle(); acc(1, 2'd0, 0, 1, 4'hC, 0); step();
    idle(); acc(1, 2'd1, 1, 0, 4'h2, 32'h00005500); step();
    idle(); acc(1, 2'd1, 1, 0, 4'h1, 32'h00000077); acc(0, 2'd0, 0, 1, 4'h1, 0); step();
    peek(2'd3, 2'd3);

    // R10: write to the inbox register is ignored
    req = "R10";
    idle(); acc(0, 2'd0, 1, 0, 4'hF, 32'hDEADBEEF); step();
    peek(2'd0, 2'd3);

    // R3: status mirrors on both sides with flags in both nibbles
    req = "R3";
    idle(); acc(0, 2'd1, 1, 0, 4'h9, 32'h11223344); acc(1, 2'd1, 1, 0, 4'h6, 32'h55667788); step();
    peek(2'd3, 2'd3);

    // R4: flush from the add-on while the host writes
    req = "R4";
    idle(); acc(1, 2'd3, 1, 0, 4'h8, 32'h08000000); acc(0, 2'd1, 1, 0, 4'hF, 32'hCAFEF00D); step();
    peek(2'd3, 2'd1);
    idle(); acc(0, 2'd3, 1, 0, 4'h7, 32'h08000000); step();
    peek(2'd3, 2'd0);

    // R5: control layout and byte-enable gating
    req = "R5";
    idle(); acc(0, 2'd2, 1, 0, 4'h1, 32'h0000_0029); step();
    idle(); acc(0, 2'd2, 1, 0, 4'h2, 32'h0000_0000); step();
    peek(2'd2, 2'd2);

    // R6: host inbound lane 2, add-on writes lanes 1 then 2
    req = "R6";
    idle(); acc(1, 2'd1, 1, 0, 4'h2, 32'h0000AA00); step();
    peek(2'd2, 2'd2);
    idle(); acc(1, 2'd1, 1, 0, 4'h4, 32'h00BB0000); step();
    peek(2'd2, 2'd3);
    // add-on outbound on lane 3: host reads lane 0, then lane 3
    idle(); acc(1, 2'd2, 1, 0, 4'h1, 32'h0000_0032); step();
    idle(); acc(0, 2'd0, 0, 1, 4'h1, 0); step();
    idle(); acc(0, 2'd0, 0, 1, 4'h8, 0); step();
    peek(2'd2, 2'd2);

    // R7: disabling keeps the flag, writing 0 keeps it, writing 1 clears it
    req = "R7";
    idle(); acc(0, 2'd2, 1, 0, 4'h1, 32'h0); step();
    idle(); acc(0, 2'd2, 1, 0, 4'h3, 32'h0); step();
    peek(2'd2, 2'd2);
    idle(); acc(0, 2'd2, 1, 0, 4'h2, 32'h0000_0100); step();
    peek(2'd2, 2'd2);
    // set wins over clear: add-on out flag set by host read while add-on clears it
    idle(); acc(1, 2'd2, 1, 0, 4'h2, 32'h0000_0200); acc(0, 2'd0, 0, 1, 4'h8, 0); step();
    peek(2'd2, 2'd2);

    // R8: irq follows the OR of the flags
    req = "R8";
    idle(); acc(1, 2'd2, 1, 0, 4'h2, 32'h0000_0300); step();
    peek(2'd2, 2'd2);

    // mixed traffic from both sides
    req = "R2";
    for (int n = 0; n < 600; n++) begin
      idle();
      for (int s = 0; s < 2; s++) begin
        int c = int'($urandom_range(0, 5));
        logic [31:0] wd = $urandom;
        if (($urandom_range(0, 7)) != 0) wd[27] = 1'b0;
        acc(s, 2'($urandom_range(0, 3)), c < 2, c == 2 || c == 3, 4'($urandom), wd);
      end
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule